// File: doc/BRIEF.md
# Event-Driven Match Timer

This block is a free-running up-counter whose period is not fixed at synthesis time. A bank of compare values is held next to the counter. Each of a set of event slots picks one compare value and raises its output for one cycle when the counter holds that value. Any event may also be marked as a limit event. When a limit event fires, the counter restarts from zero on its next advance. One event used this way defines a period, and the other events placed at offsets inside that period produce edges for pulse-width outputs.

Each compare value has a shadow copy. Software writes the next value into the shadow. The whole bank then takes the shadow values in the same cycle the counter restarts because of a limit event, so a new duty cycle never starts partway through a period. A configuration bit turns this copy off. A programmable divider sets how many clock cycles make one counter step. A halt bit freezes the counter and keeps every event silent. A write-only clear bit zeroes the count and the divider phase.

Registers are reached through a simple write strobe and a read strobe. Read data is registered and appears on the cycle after the read strobe.

Top module: `mtimer_top`

## Requirements
- R1: After reset the control register (offset 0x004) reads 0x0000_0004, meaning halt is set and the prescale is 0. The configuration register (offset 0x000) reads 0, and every bit of `ev_out` is low.
- R2: The counter advances only when all three of these hold: configuration bit 0 (unified 32-bit mode) is 1, control bit 2 (halt) is 0, and control bit 4 (reverse count) is 0. In any other setting no event fires.
- R3: With the control field at bits 12:5 set to p, the counter advances once every p+1 clock cycles. Each event pulse on `ev_out` lasts exactly one cycle per counter value.
- R4: Event n is configured through two registers. Its control register at 0x304+8n selects a compare index in bits 3:0, and bits 13:12 must equal 1 (fire on match). Its mask register at 0x300+8n must have bit 0 set. An event configured this way fires on an advancing cycle in which its selected compare value equals the counter, and `ev_out[n]` is high on the following cycle.
- R5: An event does not fire if its bits 13:12 hold any code other than 1, which includes an all-zero control word. It also does not fire if its mask bit 0 is clear.
- R6: Bit n of the limit register (0x008) marks event n as a limit event. When a limit event fires, the counter loads 0 instead of counting up. A compare value of N-1 on a limit event therefore gives a period of N advances.
- R7: Compare value n is at 0x100+4n and its shadow is at 0x200+4n. A write to a compare value takes effect at once. All shadows are copied into the compare values in the cycle the counter wraps because of a limit event.
- R8: When configuration bit 7 is set, the shadow copy at a limit wrap is suppressed and the compare values keep their contents.
- R9: Writing 1 to control bit 3 zeroes the counter and the divider phase in that cycle. The bit always reads 0.
- R10: A read returns the stored value of the addressed register on the cycle after `rd_en`. Bits with no storage read 0.
- R11: Several events may fire in the same cycle. For example, an event placed at the limit value pulses together with the limit event.

Note that R6 and R7 use different addressing: the limit register is a bitmask over event numbers, while the compare and shadow registers are addressed by compare index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_en` |
| ev_out | output | 16 | Events that fired on the previous advancing cycle |

## Verification
A bad count or a bad compare value shows up as pulse spacing that differs from the programmed period or offset. It is visible within one period at the chosen prescale, so the bench measures the distance between pulses in clock cycles. A shadow copy made at the wrong moment, or made when it should be suppressed, is seen in the first period after the next limit wrap, because the duty pulse keeps or changes its offset. A halted counter that still advances, or an event that should be disabled, is seen as a stray pulse inside a quiet window of a few tens of cycles.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam logic [3:0] PG_CTRL   = 4'h0;
  localparam logic [3:0] PG_MATCH  = 4'h1;
  localparam logic [3:0] PG_SHADOW = 4'h2;
  localparam logic [3:0] PG_EVENT  = 4'h3;

  localparam logic [7:0] OFS_CFG   = 8'h00;
  localparam logic [7:0] OFS_CTL   = 8'h04;
  localparam logic [7:0] OFS_LIMIT = 8'h08;

  localparam int CFG_UNIFY_B  = 0;
  localparam int CFG_NOCOPY_B = 7;
  localparam int CTL_HALT_B   = 2;
  localparam int CTL_CLR_B    = 3;
  localparam int CTL_REV_B    = 4;
  localparam int CTL_PRE_LSB  = 5;
  localparam int EV_CODE_LSB  = 12;

  localparam logic [1:0] CODE_ON_MATCH = 2'd1;
endpackage

// File: rtl/mtimer_prescaler.sv
module mtimer_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] phase;

  assign tick = run && (phase >= div);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) phase <= '0;
    else if (tick)          phase <= '0;
    else                    phase <= phase + 1'b1;
  end
endmodule

// File: rtl/mtimer_match_bank.sv
module mtimer_match_bank #(
  parameter int CNT_W = 32,
  parameter int NUM_M = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_act,
  input  logic             wr_shd,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             copy,
  output logic [CNT_W-1:0] act [NUM_M],
  output logic [CNT_W-1:0] shd [NUM_M]
);
  for (genvar g = 0; g < NUM_M; g++) begin : g_slot
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

    always_ff @(posedge clk) begin
      if (rst)                            act[g] <= '0;
      else if (wr_act && wr_idx == MY_IDX) act[g] <= wr_val;
      else if (copy)                      act[g] <= shd[g];
    end

    always_ff @(posedge clk) begin
      if (rst)                            shd[g] <= '0;
      else if (wr_shd && wr_idx == MY_IDX) shd[g] <= wr_val;
    end
  end
endmodule

// File: rtl/mtimer_event_unit.sv
module mtimer_event_unit #(
  parameter int CNT_W = 32,
  parameter int NUM_M = 16,
  parameter int NUM_E = 16,
  parameter int IDX_W = 4
) (
  input  logic             fire_ok,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] act [NUM_M],
  input  logic [IDX_W-1:0] sel [NUM_E],
  input  logic [NUM_E-1:0] armed,
  output logic [NUM_E-1:0] hit
);
  for (genvar e = 0; e < NUM_E; e++) begin : g_ev
    logic match_eq;
    always_comb begin
      match_eq = 1'b0;
      for (int m = 0; m < NUM_M; m++) begin
        if (sel[e] == IDX_W'(m) && act[m] == cnt) match_eq = 1'b1;
      end
    end
    assign hit[e] = fire_ok && armed[e] && match_eq;
  end
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int NUM_M  = 16,
  parameter int NUM_E  = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_E-1:0]  ev_out
);
  import mtimer_pkg::*;

  localparam int MI_W = (NUM_M > 1) ? $clog2(NUM_M) : 1;
  localparam int EI_W = (NUM_E > 1) ? $clog2(NUM_E) : 1;

  // write decode
  logic [3:0]      wpg, rpg;
  logic [7:0]      wofs, rofs;
  logic [MI_W-1:0] w_midx, r_midx;
  logic [EI_W-1:0] w_eidx, r_eidx;

  assign wpg    = wr_addr[ADDR_W-1 -: 4];
  assign wofs   = wr_addr[7:0];
  assign w_midx = wr_addr[2 +: MI_W];
  assign w_eidx = wr_addr[3 +: EI_W];
  assign rpg    = rd_addr[ADDR_W-1 -: 4];
  assign rofs   = rd_addr[7:0];
  assign r_midx = rd_addr[2 +: MI_W];
  assign r_eidx = rd_addr[3 +: EI_W];

  logic wr_cfg, wr_ctl, wr_lim, wr_act, wr_shd, wr_evc, wr_evm;
  assign wr_cfg = wr_en && wpg == PG_CTRL  && wofs == OFS_CFG;
  assign wr_ctl = wr_en && wpg == PG_CTRL  && wofs == OFS_CTL;
  assign wr_lim = wr_en && wpg == PG_CTRL  && wofs == OFS_LIMIT;
  assign wr_act = wr_en && wpg == PG_MATCH;
  assign wr_shd = wr_en && wpg == PG_SHADOW;
  assign wr_evc = wr_en && wpg == PG_EVENT && wr_addr[2];
  assign wr_evm = wr_en && wpg == PG_EVENT && !wr_addr[2];

  // configuration and control state
  logic             unify_q, nocopy_q, halt_q, rev_q;
  logic [PRE_W-1:0] pre_q;
  logic [NUM_E-1:0] limit_q;
  logic             clr;

  assign clr = wr_ctl && wr_data[CTL_CLR_B];

  always_ff @(posedge clk) begin
    if (rst) begin
      unify_q  <= 1'b0;
      nocopy_q <= 1'b0;
      halt_q   <= 1'b1;
      rev_q    <= 1'b0;
      pre_q    <= '0;
      limit_q  <= '0;
    end else begin
      if (wr_cfg) begin
        unify_q  <= wr_data[CFG_UNIFY_B];
        nocopy_q <= wr_data[CFG_NOCOPY_B];
      end
      if (wr_ctl) begin
        halt_q <= wr_data[CTL_HALT_B];
        rev_q  <= wr_data[CTL_REV_B];
        pre_q  <= wr_data[CTL_PRE_LSB +: PRE_W];
      end
      if (wr_lim) limit_q <= wr_data[NUM_E-1:0];
    end
  end

  // per-event configuration
  logic [MI_W-1:0]   ev_sel  [NUM_E];
  logic [1:0]        ev_code [NUM_E];
  logic [DATA_W-1:0] ev_mask [NUM_E];
  logic [NUM_E-1:0]  ev_armed;

  for (genvar e = 0; e < NUM_E; e++) begin : g_evcfg
    localparam logic [EI_W-1:0] MY_E = EI_W'(e);
    always_ff @(posedge clk) begin
      if (rst) begin
        ev_sel[e]  <= '0;
        ev_code[e] <= '0;
        ev_mask[e] <= '0;
      end else begin
        if (wr_evc && w_eidx == MY_E) begin
          ev_sel[e]  <= wr_data[MI_W-1:0];
          ev_code[e] <= wr_data[EV_CODE_LSB +: 2];
        end
        if (wr_evm && w_eidx == MY_E) ev_mask[e] <= wr_data;
      end
    end
    assign ev_armed[e] = (ev_code[e] == CODE_ON_MATCH) && ev_mask[e][0];
  end

  // counting path
  logic             run, tick, wrap, copy;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_E-1:0] hit;
  logic [CNT_W-1:0] act [NUM_M];
  logic [CNT_W-1:0] shd [NUM_M];

  assign run  = unify_q && !halt_q && !rev_q;
  assign wrap = |(hit & limit_q);
  assign copy = wrap && !nocopy_q;

  mtimer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .clr(clr), .div(pre_q), .tick(tick)
  );

  mtimer_match_bank #(.CNT_W(CNT_W), .NUM_M(NUM_M), .IDX_W(MI_W)) u_bank (
    .clk(clk), .rst(rst), .wr_act(wr_act), .wr_shd(wr_shd), .wr_idx(w_midx),
    .wr_val(wr_data[CNT_W-1:0]), .copy(copy), .act(act), .shd(shd)
  );

  mtimer_event_unit #(.CNT_W(CNT_W), .NUM_M(NUM_M), .NUM_E(NUM_E), .IDX_W(MI_W)) u_ev (
    .fire_ok(tick), .cnt(cnt_q), .act(act), .sel(ev_sel), .armed(ev_armed), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ev_out <= '0;
    else     ev_out <= hit;
  end

  // flattened views for the bound checker
  logic [NUM_M*CNT_W-1:0] act_flat, shd_flat;
  for (genvar m = 0; m < NUM_M; m++) begin : g_flat
    assign act_flat[m*CNT_W +: CNT_W] = act[m];
    assign shd_flat[m*CNT_W +: CNT_W] = shd[m];
  end

  // readback
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (rpg)
      PG_CTRL: begin
        if (rofs == OFS_CFG) begin
          rd_mux[CFG_UNIFY_B]  = unify_q;
          rd_mux[CFG_NOCOPY_B] = nocopy_q;
        end else if (rofs == OFS_CTL) begin
          rd_mux[CTL_HALT_B]            = halt_q;
          rd_mux[CTL_REV_B]             = rev_q;
          rd_mux[CTL_PRE_LSB +: PRE_W]  = pre_q;
        end else if (rofs == OFS_LIMIT) begin
          rd_mux[NUM_E-1:0] = limit_q;
        end
      end
      PG_MATCH:  rd_mux[CNT_W-1:0] = act[r_midx];
      PG_SHADOW: rd_mux[CNT_W-1:0] = shd[r_midx];
      PG_EVENT: begin
        if (rd_addr[2]) begin
          rd_mux[MI_W-1:0]          = ev_sel[r_eidx];
          rd_mux[EV_CODE_LSB +: 2]  = ev_code[r_eidx];
        end else begin
          rd_mux = ev_mask[r_eidx];
        end
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/mtimer_checker.sv
module mtimer_checker #(
  parameter int CNT_W = 32,
  parameter int NUM_M = 16,
  parameter int NUM_E = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   run,
  input logic                   tick,
  input logic                   clr,
  input logic                   wrap,
  input logic                   nocopy,
  input logic                   wr_act,
  input logic [CNT_W-1:0]       cnt,
  input logic [NUM_M*CNT_W-1:0] act_flat,
  input logic [NUM_M*CNT_W-1:0] shd_flat,
  input logic [NUM_E-1:0]       armed,
  input logic [NUM_E-1:0]       ev_out
);
  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (ev_out == '0));

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));

  assert_unarmed_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(armed) || ((ev_out & ~armed) == '0) || $past(armed) != armed
      |-> ((ev_out & ~$past(armed)) == '0));

  assert_limit_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && wrap) |=> (cnt == '0));

  assert_step_shape_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

  assert_shadow_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (wrap && !nocopy && !wr_act) |=> (act_flat == $past(shd_flat)));

  assert_copy_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (wrap && nocopy && !wr_act) |=> $stable(act_flat));
endmodule

bind mtimer_top mtimer_checker #(.CNT_W(CNT_W), .NUM_M(NUM_M), .NUM_E(NUM_E)) u_chk (
  .clk(clk), .rst(rst), .run(run), .tick(tick), .clr(clr), .wrap(wrap),
  .nocopy(nocopy_q), .wr_act(wr_act), .cnt(cnt_q), .act_flat(act_flat),
  .shd_flat(shd_flat), .armed(ev_armed), .ev_out(ev_out)
);

// File: tb/tb_mtimer_top.sv
module tb_mtimer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] ev_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mtimer_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ev_out(ev_out)
  );

  localparam int TV_N = 5;
  localparam int TV_P [TV_N] = '{10, 7, 3, 20, 5};
  localparam int TV_D [TV_N] = '{3, 0, 1, 12, 4};
  localparam int TV_S [TV_N] = '{0, 2, 0, 1, 0};

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic sync_on(input int b);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ev_out[b]) return;
    end
  endtask

  // cycles from now to first pulse of event 1 and of event 0
  task automatic measure(output int d1, output int d0);
    d1 = -1; d0 = -1;
    for (int c = 1; c < 2000; c++) begin
      @(negedge clk);
      if (ev_out[1] && d1 < 0) d1 = c;
      if (ev_out[0] && d0 < 0) d0 = c;
      if (d1 >= 0 && d0 >= 0) return;
    end
  endtask

  task automatic pulses(input int n, output int p1, output int p0);
    p1 = 0; p0 = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (ev_out[1]) p1++;
      if (ev_out[0]) p0++;
    end
  endtask

  initial begin
    logic [31:0] r;
    int d1, d0, p1, p0, per, off;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(12'h004, r); check("R1 ctl", r, 32'h4);
    rd(12'h000, r); check("R1 cfg", r, 0);
    check("R1 ev_out", ev_out, 0);

    // R3 R4 R6 R11 vector table
    for (int i = 0; i < TV_N; i++) begin
      wr(12'h004, 32'h0000_000C);
      wr(12'h100, TV_P[i] - 1); wr(12'h200, TV_P[i] - 1);
      wr(12'h104, TV_D[i]);     wr(12'h204, TV_D[i]);
      wr(12'h300, 1); wr(12'h304, 32'h1000);
      wr(12'h308, 1); wr(12'h30C, 32'h1001);
      wr(12'h008, 1); wr(12'h000, 1);
      wr(12'h004, (TV_S[i] << 5) | 32'h8);
      sync_on(0);
      measure(d1, d0);
      off = ((TV_D[i] + 1) % TV_P[i] == 0) ? TV_P[i] : TV_D[i] + 1;
      per = TV_P[i] * (TV_S[i] + 1);
      check("R4 R11 duty offset", d1, off * (TV_S[i] + 1));
      check("R3 R6 period", d0, per);
    end

    // R7 shadow copy at wrap: P=10, D=3 -> 6
    wr(12'h004, 32'h0000_000C);
    wr(12'h100, 9); wr(12'h200, 9); wr(12'h104, 3); wr(12'h204, 3);
    wr(12'h004, 32'h8);
    sync_on(0);
    wr(12'h204, 6);
    measure(d1, d0);
    check("R7 active kept", d1, 3);
    check("R7 period", d0, 9);
    measure(d1, d0);
    check("R7 shadow taken", d1, 7);
    rd(12'h104, r); check("R10 match readback", r, 6);

    // R8 copy suppressed
    wr(12'h000, 32'h81);
    wr(12'h204, 1);
    sync_on(0);
    measure(d1, d0);
    check("R8 no copy", d1, 7);

    // R6 limit on event 1 (match1 = 6 -> period 7, event 0 never reached)
    wr(12'h008, 2);
    wr(12'h004, 32'h8);
    sync_on(1);
    measure(d1, d0);
    check("R6 limit period", d1, 7);
    pulses(30, p1, p0);
    check("R6 no event 0", p0, 0);

    // R5 disabled control code and mask
    wr(12'h008, 1);
    wr(12'h30C, 32'h0);
    wr(12'h004, 32'h8);
    pulses(25, p1, p0);
    check("R5 code 0 silent", p1, 0);
    check("R5 other event live", p0 > 0, 1);
    wr(12'h30C, 32'h2001);
    pulses(25, p1, p0);
    check("R5 code 2 silent", p1, 0);
    wr(12'h30C, 32'h1001); wr(12'h308, 0);
    pulses(25, p1, p0);
    check("R5 mask clear silent", p1, 0);
    wr(12'h308, 1);

    // R2 run conditions
    wr(12'h000, 0);
    pulses(30, p1, p0); check("R2 unify off", p0 + p1, 0);
    wr(12'h000, 1); wr(12'h004, 32'h4);
    pulses(30, p1, p0); check("R2 halted", p0 + p1, 0);
    wr(12'h004, 32'h10);
    pulses(30, p1, p0); check("R2 reverse set", p0 + p1, 0);

    // R9 clear
    wr(12'h004, 32'h8);
    measure(d1, d0);
    check("R9 restart from zero", d0, 10);
    rd(12'h004, r); check("R9 clear reads 0", r, 0);

    summary();
  end
endmodule